// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps an SDRAM refreshed at the rate its retention period demands. A free-running interval timer earns one refresh credit every refresh period. The period is derived from the clock frequency, the retention time and the number of refreshes needed per retention window. Credits accumulate in a small saturating counter, so the command arbiter may postpone refreshes while normal traffic is busy.

While credits are outstanding and no sequence is running, the block raises a request to the arbiter. When the arbiter grants it, the block owns the command bus. If any bank still has a row open, it first closes all banks with a PRECHARGE-all command. It then waits the row-precharge time and issues one AUTO REFRESH. After that it holds the bus for the refresh cycle time before releasing it.

Every command carries the same address word, with only the all-banks select bit set, because the device supplies the refreshed row itself. An urgent flag tells the arbiter when the credit store is full, so that no further postponement is possible. The controller owns the per-bank open flags. It is expected to keep a bank's flag high until that bank's own precharge time has elapsed.

Top module: `rfsh_sched`

## Requirements
- R1: The refresh period is INTERVAL = floor(CLK_MHZ*1000*RETENTION_MS/REFRESH_COUNT) clock cycles. One credit is earned every INTERVAL cycles. The first credit becomes visible INTERVAL cycles after reset is released.
- R2: `rf_req` is high exactly when `busy` is low and at least one credit is held. Each AUTO REFRESH uses up one credit. A grant starts exactly one sequence, and each sequence issues exactly one AUTO REFRESH.
- R3: The credit count saturates at PEND_MAX, and a credit earned at saturation is dropped. `rf_urgent` is high exactly when the count equals PEND_MAX.
- R4: A grant is `rf_req` and `rf_gnt` both high at a clock edge. In the cycle after a grant, `cmd_op` is 2'b01 (PRECHARGE-all) if any `bank_open` bit was high at that edge. Otherwise it is 2'b10 (AUTO REFRESH). When SKIP_IDLE_PREA is 0, PRECHARGE-all is always issued.
- R5: The AUTO REFRESH of a sequence comes exactly T_RP cycles after the PRECHARGE-all of that sequence. It is never issued while any `bank_open` bit is high.
- R6: If AUTO REFRESH is issued in cycle r, then `busy` is high from the grant through cycle r+T_RFC-1, with `cmd_op` at 2'b00 after the refresh. `busy` is low in cycle r+T_RFC.
- R7: `cmd_op` is 2'b00 whenever no command is issued. During every command, `cmd_addr` has only bit AP_BIT set.
- R8: During and right after reset, `rf_req`, `rf_urgent` and `busy` are low and `cmd_op` is 2'b00.
- R9: With every request granted in the cycle it appears, each window of CLK_MHZ*1000*RETENTION_MS cycles contains at least REFRESH_COUNT AUTO REFRESH commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_open | input | NUM_BANKS | High for each bank with an open row |
| rf_gnt | input | 1 | Arbiter grant of the command bus |
| rf_req | output | 1 | Refresh wanted, sequence idle |
| rf_urgent | output | 1 | Credit store full, refresh must not be postponed further |
| busy | output | 1 | Refresh sequence owns the command bus |
| cmd_op | output | 2 | 00 none, 01 PRECHARGE-all, 10 AUTO REFRESH |
| cmd_addr | output | ADDR_W | Fixed address word, only bit AP_BIT set |

## Verification
A credit count that drifts from the true number of earned and spent refreshes shows up at the ports. Within one cycle, `rf_req` stays high after the last refresh, or `rf_urgent` disagrees with saturation. Over a retention window, the same fault also appears as a shortfall in the refresh count. A sequencer wait counter that is off by one moves the AUTO REFRESH, or the fall of `busy`, by one cycle relative to the grant, so a cycle-exact expected command stream exposes it at once. A wrong choice between the precharge and direct paths shows up in the first command after the grant.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   typedef enum logic [1:0] {
      RF_CMD_NOP  = 2'b00,
      RF_CMD_PREA = 2'b01,
      RF_CMD_AREF = 2'b10
   } rf_cmd_e;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_PREA = 3'd1,
      SQ_WRP  = 3'd2,
      SQ_AREF = 3'd3,
      SQ_WRFC = 3'd4
   } sq_state_e;

   // refresh period in clock cycles, rounded down so the rate is never short
   function automatic int unsigned rf_interval(input int unsigned mhz,
                                               input int unsigned ms,
                                               input int unsigned count);
      return (mhz * 1000 * ms) / count;
   endfunction

endpackage

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
   parameter int unsigned INTERVAL = 390
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
   localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= RELOAD;
      else if (cnt_q == '0)   cnt_q <= RELOAD;
      else                    cnt_q <= cnt_q - 1'b1;
   end

   assign tick = (cnt_q == '0);

   // checker: independent up-counter of cycles since the last tick
   logic [CW:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    gap_q <= '0;
      else if (tick) gap_q <= '0;
      else           gap_q <= gap_q + 1'b1;
   end

   p_tick_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (gap_q == (CW+1)'(INTERVAL - 1)))
      else $error("tick spacing differs from INTERVAL");

   p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick)
      else $error("tick lasted more than one cycle");

endmodule

// File: rtl/rfsh_pend_ctr.sv
module rfsh_pend_ctr #(
   parameter int unsigned PEND_MAX = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic take,
   output logic pend_nz,
   output logic sat
);
   localparam int PW = $clog2(PEND_MAX + 1);
   localparam logic [PW-1:0] TOP = PW'(PEND_MAX);

   logic [PW-1:0] cnt_q, cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (tick && !take && (cnt_q != TOP)) cnt_d = cnt_q + 1'b1;
      else if (take && !tick)              cnt_d = cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign pend_nz = (cnt_q != '0);
   assign sat     = (cnt_q == TOP);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TOP)
      else $error("credit count above PEND_MAX");

   p_take_has_credit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (cnt_q != '0))
      else $error("refresh issued without a credit");

   p_sat_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sat && tick && !take) |=> sat)
      else $error("saturated count changed on tick");

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
   import rfsh_pkg::*;
#(
   parameter int unsigned NUM_BANKS      = 4,
   parameter int unsigned T_RP           = 3,
   parameter int unsigned T_RFC          = 9,
   parameter bit          SKIP_IDLE_PREA = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pend_nz,
   input  logic [NUM_BANKS-1:0] bank_open,
   input  logic                 rf_gnt,
   output logic                 rf_req,
   output logic                 busy,
   output rf_cmd_e              cmd,
   output logic                 take
);
   localparam int unsigned WMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int WW = $clog2(WMAX);
   localparam int SW = $clog2(T_RP + 1);

   sq_state_e     state_q, state_d;
   logic [WW-1:0] wcnt_q, wcnt_d;
   logic          need_prea;

   generate
      if (SKIP_IDLE_PREA) begin : g_skip_idle
         assign need_prea = |bank_open;
      end else begin : g_always_prea
         assign need_prea = 1'b1;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      wcnt_d  = wcnt_q;
      unique case (state_q)
         SQ_IDLE: if (pend_nz && rf_gnt) state_d = need_prea ? SQ_PREA : SQ_AREF;
         SQ_PREA: begin
            state_d = SQ_WRP;
            wcnt_d  = WW'(T_RP - 2);
         end
         SQ_WRP: begin
            if (wcnt_q == '0) state_d = SQ_AREF;
            else              wcnt_d  = wcnt_q - 1'b1;
         end
         SQ_AREF: begin
            state_d = SQ_WRFC;
            wcnt_d  = WW'(T_RFC - 2);
         end
         SQ_WRFC: begin
            if (wcnt_q == '0) state_d = SQ_IDLE;
            else              wcnt_d  = wcnt_q - 1'b1;
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         wcnt_q  <= '0;
      end else begin
         state_q <= state_d;
         wcnt_q  <= wcnt_d;
      end
   end

   assign rf_req = (state_q == SQ_IDLE) && pend_nz;
   assign busy   = (state_q != SQ_IDLE);
   assign take   = (state_q == SQ_AREF);

   always_comb begin
      unique case (state_q)
         SQ_PREA: cmd = RF_CMD_PREA;
         SQ_AREF: cmd = RF_CMD_AREF;
         default: cmd = RF_CMD_NOP;
      endcase
   end

   // checker: cycles since the last PRECHARGE-all, saturating at T_RP
   logic [SW-1:0] since_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   since_q <= SW'(T_RP);
      else if (cmd == RF_CMD_PREA)  since_q <= SW'(1);
      else if (since_q < SW'(T_RP)) since_q <= since_q + 1'b1;
   end

   p_trp_met_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == RF_CMD_AREF) |-> (since_q >= SW'(T_RP)))
      else $error("AUTO REFRESH before tRP elapsed");

   p_banks_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == RF_CMD_AREF) |-> (bank_open == '0))
      else $error("AUTO REFRESH with a bank open");

   p_grant_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_req && rf_gnt) |=> (busy && (cmd != RF_CMD_NOP)))
      else $error("grant did not start a sequence");

   p_rfc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == RF_CMD_AREF) |=> (busy && (cmd == RF_CMD_NOP)))
      else $error("bus released right after AUTO REFRESH");

   p_no_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rf_req)
      else $error("request raised during a sequence");

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
   import rfsh_pkg::*;
#(
   parameter int unsigned CLK_MHZ        = 100,
   parameter int unsigned RETENTION_MS   = 64,
   parameter int unsigned REFRESH_COUNT  = 8192,
   parameter int unsigned NUM_BANKS      = 4,
   parameter int unsigned ADDR_W         = 13,
   parameter int unsigned AP_BIT         = 10,
   parameter int unsigned PEND_MAX       = 8,
   parameter int unsigned T_RP           = 3,
   parameter int unsigned T_RFC          = 9,
   parameter bit          SKIP_IDLE_PREA = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] bank_open,
   input  logic                 rf_gnt,
   output logic                 rf_req,
   output logic                 rf_urgent,
   output logic                 busy,
   output logic [1:0]           cmd_op,
   output logic [ADDR_W-1:0]    cmd_addr
);
   localparam int unsigned INTERVAL = rf_interval(CLK_MHZ, RETENTION_MS, REFRESH_COUNT);
   localparam logic [ADDR_W-1:0] PREA_ADDR = ADDR_W'(1) << AP_BIT;

   initial begin
      a_cfg_interval: assert (INTERVAL > T_RP + T_RFC + 2)
         else $error("refresh period too short for one sequence");
      a_cfg_trp: assert (T_RP >= 2) else $error("T_RP must be at least 2");
      a_cfg_trfc: assert (T_RFC >= 2) else $error("T_RFC must be at least 2");
      a_cfg_pend: assert (PEND_MAX >= 1) else $error("PEND_MAX must be at least 1");
      a_cfg_apbit: assert (AP_BIT < ADDR_W) else $error("AP_BIT outside address");
      a_cfg_banks: assert (NUM_BANKS >= 1) else $error("NUM_BANKS must be at least 1");
   end

   logic    tick, take, pend_nz, sat;
   rf_cmd_e cmd;

   rfsh_tick_gen #(.INTERVAL(INTERVAL)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   rfsh_pend_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .take    (take),
      .pend_nz (pend_nz),
      .sat     (sat)
   );

   rfsh_seq #(
      .NUM_BANKS      (NUM_BANKS),
      .T_RP           (T_RP),
      .T_RFC          (T_RFC),
      .SKIP_IDLE_PREA (SKIP_IDLE_PREA)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_nz   (pend_nz),
      .bank_open (bank_open),
      .rf_gnt    (rf_gnt),
      .rf_req    (rf_req),
      .busy      (busy),
      .cmd       (cmd),
      .take      (take)
   );

   assign rf_urgent = sat;
   assign cmd_op    = cmd;
   assign cmd_addr  = PREA_ADDR;

   p_urgent_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rf_urgent |-> (rf_req || busy))
      else $error("urgent without request or sequence");

   p_cmd_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op != 2'b11) && (!busy -> (cmd_op == 2'b00)))
      else $error("command outside a sequence");

endmodule

// File: tb/test_rfsh_sched.sv
module test_rfsh_sched;
   localparam int CLK_MHZ = 50;
   localparam int RET_MS  = 1;
   localparam int RCOUNT  = 128;
   localparam int NB      = 4;
   localparam int AW      = 13;
   localparam int APB     = 10;
   localparam int PMAX    = 8;
   localparam int TRP     = 3;
   localparam int TRFC    = 7;
   localparam int INTV    = (CLK_MHZ * 1000 * RET_MS) / RCOUNT;
   localparam int WIN     = CLK_MHZ * 1000 * RET_MS;
   localparam int PH_A    = 10 * INTV;
   localparam int PH_B    = PH_A + 30000;
   localparam int PH_C    = PH_B + 60000;
   localparam int WSTART  = PH_B + 2000;
   localparam logic [AW-1:0] EXP_ADDR = AW'(1) << APB;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NB-1:0] bank_open;
   logic          rf_gnt;
   logic          rf_req, rf_urgent, busy;
   logic [1:0]    cmd_op;
   logic [AW-1:0] cmd_addr;

   always #10 clk = ~clk;

   rfsh_sched #(
      .CLK_MHZ(CLK_MHZ), .RETENTION_MS(RET_MS), .REFRESH_COUNT(RCOUNT),
      .NUM_BANKS(NB), .ADDR_W(AW), .AP_BIT(APB), .PEND_MAX(PMAX),
      .T_RP(TRP), .T_RFC(TRFC), .SKIP_IDLE_PREA(1'b1)
   ) i_rfsh_sched (
      .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .rf_gnt(rf_gnt),
      .rf_req(rf_req), .rf_urgent(rf_urgent), .busy(busy),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d time=%0t", rq, act, exp, $time);
      end
   endtask

   function automatic int exp_cmd(input int c, input int pre_at, input int ref_at);
      if (c == pre_at) return 1;
      if (c == ref_at) return 2;
      return 0;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int      m_pend;
      int      pre_at, ref_at, seq_start, busy_until, win_refs;
      int      e_cmd;
      bit      e_busy, e_req, tick, new_gnt;
      logic [NB-1:0] nb;
      void'($urandom(32'd2024));
      m_pend = 0; pre_at = -1; ref_at = -1; seq_start = -1; busy_until = -2; win_refs = 0;
      rst_n = 1'b0; rf_gnt = 1'b0; bank_open = '0;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(rf_req == 1'b0,    "R8", rf_req, 0);
      chk(rf_urgent == 1'b0, "R8", rf_urgent, 0);
      chk(busy == 1'b0,      "R8", busy, 0);
      chk(cmd_op == 2'b00,   "R8", cmd_op, 0);
      rst_n = 1'b1;
      for (int c = 0; c < PH_C; c++) begin
         e_busy = (c >= seq_start) && (c <= busy_until);
         e_req  = !e_busy && (m_pend > 0);
         e_cmd  = exp_cmd(c, pre_at, ref_at);
         chk(rf_urgent == (m_pend == PMAX), "R3", rf_urgent, int'(m_pend == PMAX));
         chk(rf_req == e_req, "R2", rf_req, e_req);
         chk(busy == e_busy, "R6", busy, e_busy);
         if (e_cmd == 1)      chk(cmd_op == 2'b01, "R4", cmd_op, e_cmd);
         else if (e_cmd == 2) chk(cmd_op == 2'b10, "R5", cmd_op, e_cmd);
         else                 chk(cmd_op == 2'b00, "R7", cmd_op, e_cmd);
         if (cmd_op != 2'b00) chk(cmd_addr == EXP_ADDR, "R7", cmd_addr, EXP_ADDR);
         if (cmd_op == 2'b10) chk(bank_open == '0, "R5", bank_open, 0);
         if (c == INTV - 1)        chk(rf_req == 1'b0, "R1", rf_req, 0);
         if (c == INTV)            chk(rf_req == 1'b1, "R1", rf_req, 1);
         if (c == PMAX * INTV - 1) chk(rf_urgent == 1'b0, "R3", rf_urgent, 0);
         if (c == PMAX * INTV)     chk(rf_urgent == 1'b1, "R3", rf_urgent, 1);
         if (cmd_op == 2'b10 && c >= WSTART && c < WSTART + WIN) win_refs++;

         // credit model for the next edge
         tick = ((c + 1) % INTV) == 0;
         if (tick && e_cmd != 2 && m_pend < PMAX) m_pend++;
         else if (e_cmd == 2 && !tick)            m_pend--;

         // stimulus for the next edge
         if (c < PH_A)      new_gnt = 1'b0;
         else if (c < PH_B) new_gnt = ($urandom % 4) == 0;
         else               new_gnt = 1'b1;
         nb = bank_open;
         if (e_cmd == 1) nb = '0;
         else if (!e_busy || c == busy_until) begin
            if (($urandom % 3) == 0) nb = NB'($urandom);
         end
         if (e_req && new_gnt) begin
            seq_start = c + 1;
            if (|nb) begin
               pre_at = c + 1;
               ref_at = c + 1 + TRP;
            end else begin
               ref_at = c + 1;
            end
            busy_until = ref_at + TRFC - 1;
         end
         rf_gnt    = new_gnt;
         bank_open = nb;
         @(negedge clk);
      end
      // R9: refresh count over one retention window with prompt grants
      chk(win_refs >= RCOUNT, "R9", win_refs, RCOUNT);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule